// File: doc/BRIEF.md
# Cyclic-Shift Code-Set Chip Spreader

This block turns a stream of 4-bit data symbols into serial chips for a direct-sequence offset-QPSK transmitter. Each symbol selects one codeword of a sixteen-word code set. The set is built at run time from a single root word: the top symbol bit chooses between the root and the root with its odd-indexed chips inverted, and the low three bits set a cyclic rotation of that base word. A parameter picks the code length of 8 or 16 chips. No codeword table is stored.

Chips leave the block one per chip-enable strobe. An optional cyclic prefix of 0, 1 or 2 chips can be placed ahead of each codeword, and its length is set for each symbol. The chip stream is split into an in-phase and a quadrature output: the I output takes chips at even stream positions and the Q output takes chips at odd positions, so Q changes one chip period after I. Symbols arrive on a valid/ready handshake, and a new symbol is taken only on the strobe that follows the last chip of the current one.

Top module: `chip_spreader`

## Requirements
- R1: A synchronous active-high reset clears chip_vld, chip_i and chip_q to 0 and leaves the block idle, so sym_ready equals chip_en afterwards. A symbol whose chips were being sent when the reset arrived produces no further chips.
- R2: With symbol bit 3 clear, the base word is the root. The root is 01011100 for the 8-chip set and 0010111101010011 for the 16-chip set, with chip 0 the leftmost bit and chip 0 sent first.
- R3: With symbol bit 3 set, every odd-indexed chip of the root (index 1, 3, 5, ...) is inverted before rotation. Example: 8-chip symbol 9 is 10000100, and 16-chip symbol 8 is 0111101000000110.
- R4: The base word is rotated right by k = symbol[2:0] positions in the 8-chip set and by 2k positions in the 16-chip set. Example: 16-chip symbol 1 is 1100101111010100.
- R5: With a prefix length E, each symbol is sent as the last E codeword chips in codeword order, followed by codeword chips 0 to N-1. The symbol lasts N+E strobes.
- R6: ext_len is sampled on the strobe that accepts the symbol, and a later change has no effect on that symbol. The value 3 is treated as 2.
- R7: A chip at an even position of the symbol's stream is placed on chip_i, and a chip at an odd position is placed on chip_q. Stream positions count from 0 and include the prefix chips. The output that does not take the chip holds its value.
- R8: sym_ready is high only during a strobe on which the block is idle or is sending the last chip of a symbol. A symbol held valid is accepted there, and its first chip follows the previous last chip with no gap.
- R9: On a strobe when no chip is due and no symbol is offered, chip_vld goes low and chip_i and chip_q hold their values.
- R10: chip_i, chip_q and chip_vld change only on clock edges where chip_en is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Chip-rate strobe; one chip is sent per strobe |
| sym_valid | input | 1 | A symbol is offered on sym_data |
| sym_data | input | 4 | Data symbol; bit 3 selects inversion, bits 2:0 set the rotation |
| ext_len | input | 2 | Number of cyclic prefix chips (0 to 2; 3 acts as 2) |
| sym_ready | output | 1 | Symbol is accepted on this edge when sym_valid is high |
| chip_i | output | 1 | In-phase chip (even stream positions) |
| chip_q | output | 1 | Quadrature chip (odd stream positions) |
| chip_vld | output | 1 | A chip was sent on the last strobe |

## Verification
Every symbol value 0 to 15 is sent back to back in both code lengths. Symbols with bit 3 clear test the root and the rotation step alone. Symbols with bit 3 set show whether inversion comes before rotation, because the other order gives different chips for odd rotations in the 8-chip set. Prefix lengths 1, 2 and 3 are sent with odd and even rotations. An odd prefix moves every codeword chip to the other output, which shows whether the I/Q split follows stream position. A second pass uses a slower strobe and gaps between symbols to test idle behaviour and that the outputs hold between strobes. A reset in the middle of a symbol checks that the remaining chips are dropped.

// File: rtl/spread_pkg.sv
package spread_pkg;

    // Largest cyclic prefix, in chips
    localparam int EXT_MAX = 2;

    // One chip handed from the sequencer to the I/Q stage
    typedef struct packed {
        logic vld;   // a chip is sent on this strobe
        logic val;   // chip value
        logic odd;   // odd stream position -> quadrature rail
    } spread_chip_t;

    // Root word, chip 0 in the most significant used bit
    function automatic logic [15:0] root_word(input int n);
        return (n == 8) ? 16'h005C : 16'h2F53;
    endfunction

    // Mask of the odd-indexed chips (chip i lives at bit n-1-i)
    function automatic logic [15:0] odd_chip_mask(input int n);
        logic [15:0] m;
        m = '0;
        for (int i = 1; i < n; i += 2) begin
            m[n-1-i] = 1'b1;
        end
        return m;
    endfunction

    // Prefix lengths above the maximum fall back to the maximum
    function automatic logic [1:0] clamp_ext(input logic [1:0] e);
        return (e > 2'(EXT_MAX)) ? 2'(EXT_MAX) : e;
    endfunction

endpackage

// File: rtl/spread_codegen.sv
module spread_codegen
    import spread_pkg::*;
#(
    parameter int NCHIP = 16
) (
    input  logic [3:0]       sym,
    output logic [NCHIP-1:0] word
);
    localparam int RW = $clog2(NCHIP);
    localparam logic [15:0] ROOT16 = root_word(NCHIP);
    localparam logic [15:0] MASK16 = odd_chip_mask(NCHIP);
    localparam logic [NCHIP-1:0] ROOT = ROOT16[NCHIP-1:0];
    localparam logic [NCHIP-1:0] OMASK = MASK16[NCHIP-1:0];

    logic [RW-1:0]      rot;
    logic [NCHIP-1:0]   base;
    logic [2*NCHIP-1:0] dbl;

    // Rotation step depends on the code length
    generate
        if (NCHIP == 16) begin : g_rot_double
            assign rot = {sym[2:0], 1'b0};
        end else begin : g_rot_single
            assign rot = RW'(sym[2:0]);
        end
    endgenerate

    // Inversion first, then rotation
    always_comb begin
        base = sym[3] ? (ROOT ^ OMASK) : ROOT;
        dbl  = {base, base} >> rot;
        word = dbl[NCHIP-1:0];
    end
endmodule

// File: rtl/spread_sequencer.sv
module spread_sequencer
    import spread_pkg::*;
#(
    parameter int NCHIP = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         chip_en,
    input  logic         sym_valid,
    input  logic [3:0]   sym_data,
    input  logic [1:0]   ext_len,
    output logic         sym_ready,
    output spread_chip_t chip_out
);
    localparam int PW = $clog2(NCHIP + EXT_MAX);

    logic [NCHIP-1:0] gen_word;
    logic [NCHIP-1:0] word_q;
    logic [PW-1:0]    pos_q;
    logic [PW-1:0]    last_q;
    logic [1:0]       ext_q;
    logic             busy_q;

    logic             at_end, accept, advance;
    logic [1:0]       ext_c, n_ext;
    logic [PW-1:0]    n_pos, idx;
    logic [NCHIP-1:0] n_word, shifted;

    spread_codegen #(.NCHIP(NCHIP)) u_codegen (
        .sym  (sym_data),
        .word (gen_word)
    );

    assign ext_c     = clamp_ext(ext_len);
    assign at_end    = !busy_q || (pos_q == last_q);
    assign sym_ready = chip_en && at_end;
    assign accept    = sym_ready && sym_valid;
    assign advance   = chip_en && busy_q && (pos_q != last_q);

    // Chip due on this strobe: prefix chips come from the codeword tail
    always_comb begin
        n_word = accept ? gen_word : word_q;
        n_pos  = accept ? '0 : pos_q + PW'(1);
        n_ext  = accept ? ext_c : ext_q;
        if (n_pos < PW'(n_ext)) begin
            idx = PW'(NCHIP) - PW'(n_ext) + n_pos;
        end else begin
            idx = n_pos - PW'(n_ext);
        end
        shifted       = n_word << idx;
        chip_out.vld  = accept || advance;
        chip_out.val  = shifted[NCHIP-1];
        chip_out.odd  = n_pos[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pos_q  <= '0;
            last_q <= '0;
            ext_q  <= '0;
            word_q <= '0;
        end else if (chip_en) begin
            if (accept) begin
                busy_q <= 1'b1;
                pos_q  <= '0;
                ext_q  <= ext_c;
                last_q <= PW'(NCHIP - 1) + PW'(ext_c);
                word_q <= gen_word;
            end else if (advance) begin
                pos_q <= pos_q + PW'(1);
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    // An accepted symbol starts at stream position 0 (R8)
    assert_accept_starts_R8: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy_q && pos_q == '0));

    // Mid-symbol strobes step the position by one (R5)
    assert_pos_steps_R5: assert property (@(posedge clk) disable iff (rst)
        advance |=> (pos_q == $past(pos_q) + PW'(1)));

    // Symbol length stays within N..N+2 chips (R6)
    assert_len_clamped_R6: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (last_q >= PW'(NCHIP - 1) && last_q <= PW'(NCHIP + EXT_MAX - 1)));

    // Last chip with nothing offered leaves the block idle (R9)
    assert_goes_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (chip_en && busy_q && pos_q == last_q && !sym_valid) |=> !busy_q);
endmodule

// File: rtl/spread_iq_split.sv
module spread_iq_split
    import spread_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         chip_en,
    input  spread_chip_t chip_in,
    output logic         chip_i,
    output logic         chip_q,
    output logic         chip_vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            chip_i   <= 1'b0;
            chip_q   <= 1'b0;
            chip_vld <= 1'b0;
        end else if (chip_en) begin
            chip_vld <= chip_in.vld;
            if (chip_in.vld) begin
                if (chip_in.odd) begin
                    chip_q <= chip_in.val;
                end else begin
                    chip_i <= chip_in.val;
                end
            end
        end
    end

    // Outputs move only on strobes (R10)
    assert_hold_between_strobes_R10: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> ($stable(chip_i) && $stable(chip_q) && $stable(chip_vld)));

    // An even-position chip leaves the quadrature rail alone (R7)
    assert_even_keeps_q_R7: assert property (@(posedge clk) disable iff (rst)
        (chip_en && chip_in.vld && !chip_in.odd) |=> $stable(chip_q));

    // An odd-position chip leaves the in-phase rail alone (R7)
    assert_odd_keeps_i_R7: assert property (@(posedge clk) disable iff (rst)
        (chip_en && chip_in.vld && chip_in.odd) |=> $stable(chip_i));

    // An empty strobe drops the valid flag (R9)
    assert_idle_drops_vld_R9: assert property (@(posedge clk) disable iff (rst)
        (chip_en && !chip_in.vld) |=> !chip_vld);
endmodule

// File: rtl/chip_spreader.sv
module chip_spreader
    import spread_pkg::*;
#(
    parameter int NCHIP = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       chip_en,
    input  logic       sym_valid,
    input  logic [3:0] sym_data,
    input  logic [1:0] ext_len,
    output logic       sym_ready,
    output logic       chip_i,
    output logic       chip_q,
    output logic       chip_vld
);
    spread_chip_t next_chip;

    spread_sequencer #(.NCHIP(NCHIP)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .chip_en   (chip_en),
        .sym_valid (sym_valid),
        .sym_data  (sym_data),
        .ext_len   (ext_len),
        .sym_ready (sym_ready),
        .chip_out  (next_chip)
    );

    spread_iq_split u_split (
        .clk      (clk),
        .rst      (rst),
        .chip_en  (chip_en),
        .chip_in  (next_chip),
        .chip_i   (chip_i),
        .chip_q   (chip_q),
        .chip_vld (chip_vld)
    );
endmodule

// File: tb/chip_spreader_test.sv
`timescale 1ns/1ps
// Tags: R1 reset, R2 root, R3 inversion, R4 rotation, R5 prefix, R6 ext sampling,
// R7 I/Q split, R8 handshake, R9 idle, R10 hold between strobes.
module chip_spreader_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic chip_en = 1'b0;
    int   stride = 1;
    int   cnt = 0;
    logic en_d = 1'b0;
    logic rst_d = 1'b1;

    logic       sv [2];
    logic [3:0] sd [2];
    logic [1:0] el [2];
    logic       sr [2];
    logic       ci [2];
    logic       cq [2];
    logic       cv [2];
    logic       last_i [2];
    logic       last_q [2];
    logic       last_v [2];

    int q0 [$];
    int q1 [$];
    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    // Instance 0: 16-chip set, instance 1: 8-chip set
    chip_spreader #(.NCHIP(16)) uut (
        .clk(clk), .rst(rst), .chip_en(chip_en), .sym_valid(sv[0]), .sym_data(sd[0]),
        .ext_len(el[0]), .sym_ready(sr[0]), .chip_i(ci[0]), .chip_q(cq[0]), .chip_vld(cv[0]));
    chip_spreader #(.NCHIP(8)) uut8 (
        .clk(clk), .rst(rst), .chip_en(chip_en), .sym_valid(sv[1]), .sym_data(sd[1]),
        .ext_len(el[1]), .sym_ready(sr[1]), .chip_i(ci[1]), .chip_q(cq[1]), .chip_vld(cv[1]));

    always @(posedge clk) begin
        if (cnt >= stride - 1) begin
            cnt <= 0;
            chip_en <= 1'b1;
        end else begin
            cnt <= cnt + 1;
            chip_en <= 1'b0;
        end
        en_d  <= chip_en;
        rst_d <= rst;
    end

    task automatic check(input bit ok, input int tag, input string what, input int got, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL R%0d %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Independent model: chip c of symbol s in an n-chip set
    function automatic bit model_chip(input int n, input bit [3:0] s, input int c);
        bit [15:0] root;
        int r, src;
        bit b;
        root = (n == 8) ? 16'h005C : 16'h2F53;
        r = (n == 8) ? int'(s[2:0]) : 2 * int'(s[2:0]);
        src = (c - r + n) % n;
        b = root[n-1-src];
        if (s[3] && (src % 2 == 1)) b = ~b;
        return b;
    endfunction

    function automatic bit [15:0] model_word(input int n, input bit [3:0] s);
        bit [15:0] w;
        w = '0;
        for (int c = 0; c < n; c++) w[n-1-c] = model_chip(n, s, c);
        return w;
    endfunction

    function automatic void push(input int k, input int v);
        if (k == 0) q0.push_back(v);
        else q1.push_back(v);
    endfunction

    function automatic int qsize(input int k);
        return (k == 0) ? q0.size() : q1.size();
    endfunction

    // Drive one symbol on instance k; called and returning at a negedge
    task automatic send(input int k, input int n, input bit [3:0] s, input bit [1:0] e, input int tag);
        int ee, c;
        sv[k] = 1'b1;
        sd[k] = s;
        el[k] = e;
        while (!sr[k]) @(negedge clk);
        @(posedge clk);
        ee = (e == 2'd3) ? 2 : int'(e);
        for (int p = 0; p < n + ee; p++) begin
            c = (p < ee) ? (n - ee + p) : (p - ee);
            push(k, int'(model_chip(n, s, c)) | ((p % 2) << 1) | (tag << 2));
        end
        @(negedge clk);
        sv[k] = 1'b0;
        el[k] = 2'd3;   // R6: change after acceptance must not matter
        sd[k] = ~s;
    endtask

    task automatic run_all(input int k, input int n);
        for (int s = 0; s < 16; s++) send(k, n, 4'(s), 2'd0, (s >= 8) ? 3 : 4);
        send(k, n, 4'd6, 2'd1, 5);    // R5
        send(k, n, 4'd13, 2'd2, 5);
        send(k, n, 4'd15, 2'd1, 5);
        send(k, n, 4'd2, 2'd3, 6);    // R6 clamp
        send(k, n, 4'd11, 2'd3, 6);
    endtask

    task automatic run_gaps(input int k, input int n);
        send(k, n, 4'd9, 2'd2, 5);
        repeat (7) @(negedge clk);
        send(k, n, 4'd1, 2'd0, 4);
        repeat (30) @(negedge clk);
        send(k, n, 4'd14, 2'd1, 3);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        for (int k = 0; k < 2; k++) begin
            if (rst_d) begin
                last_i[k] = 1'b0;
                last_q[k] = 1'b0;
                last_v[k] = 1'b0;
            end else if (en_d) begin
                if (cv[k]) begin
                    if (qsize(k) == 0) begin
                        check(1'b0, 9, "chip sent with none due", 1, 0);
                    end else begin
                        int v, tag;
                        bit odd, exp, got, other, prev;
                        v = (k == 0) ? q0.pop_front() : q1.pop_front();
                        exp = v[0];
                        odd = v[1];
                        tag = v >> 2;
                        got = odd ? cq[k] : ci[k];
                        other = odd ? ci[k] : cq[k];
                        prev = odd ? last_i[k] : last_q[k];
                        check(got == exp, tag, odd ? "chip on Q" : "chip on I", got, exp);
                        check(other == prev, 7, "untouched rail held", other, prev); // R7
                    end
                end else begin
                    // R8 no gap while chips are due; R9 idle otherwise
                    check(qsize(k) == 0, 8, "missing chip, pending", qsize(k), 0);
                end
                last_i[k] = ci[k];
                last_q[k] = cq[k];
                last_v[k] = cv[k];
            end else begin
                // R10 outputs hold between strobes
                check(ci[k] == last_i[k] && cq[k] == last_q[k] && cv[k] == last_v[k], 10,
                      "output moved between strobes", {ci[k], cq[k], cv[k]},
                      {last_i[k], last_q[k], last_v[k]});
            end
        end
    end

    task automatic check_reset_state;
        for (int k = 0; k < 2; k++) begin
            check(cv[k] == 1'b0, 1, "chip_vld after reset", cv[k], 0);
            check(ci[k] == 1'b0 && cq[k] == 1'b0, 1, "I/Q after reset", {ci[k], cq[k]}, 0);
            check(sr[k] == chip_en, 1, "sym_ready idle after reset", sr[k], chip_en);
        end
    endtask

    initial begin
        #1_000_000;
        failures++;
        $display("FAIL watchdog expired: got 1 expected 0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < 2; k++) begin
            sv[k] = 1'b0; sd[k] = 4'd0; el[k] = 2'd0;
            last_i[k] = 1'b0; last_q[k] = 1'b0; last_v[k] = 1'b0;
        end
        repeat (4) @(negedge clk);
        check_reset_state();   // R1
        rst = 1'b0;

        // Model anchored to the stated codewords (R2, R3, R4)
        check(model_word(8, 4'd0) == 16'h005C, 2, "8-chip root", model_word(8, 4'd0), 16'h005C);
        check(model_word(8, 4'd9) == 16'h0084, 3, "8-chip symbol 9", model_word(8, 4'd9), 16'h0084);
        check(model_word(16, 4'd1) == 16'hCBD4, 4, "16-chip symbol 1", model_word(16, 4'd1), 16'hCBD4);
        check(model_word(16, 4'd8) == 16'h7A06, 3, "16-chip symbol 8", model_word(16, 4'd8), 16'h7A06);

        // Back-to-back at full strobe rate
        fork
            run_all(0, 16);
            run_all(1, 8);
        join
        while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);

        // Slow strobe with idle gaps
        stride = 3;
        fork
            run_gaps(0, 16);
            run_gaps(1, 8);
        join
        while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);

        // Reset in the middle of a symbol (R1)
        fork
            send(0, 16, 4'd5, 2'd2, 2);
            send(1, 8, 4'd5, 2'd2, 2);
        join
        repeat (7) @(negedge clk);
        rst = 1'b1;
        q0.delete();
        q1.delete();
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        repeat (60) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule